// File: doc/BRIEF.md
# Programmable-Bandwidth Digital Phase-Locked Loop Core

This block is the all-digital heart of a first-order phase-locked loop. A reference signal is compared against a feedback signal that an external divide-by-N counter returns. The comparison is done by an exclusive-OR detector and an edge-triggered set/clear detector, and each detector has its own output pin. One of the two detectors, picked by a select input, steers an up/down counter that runs on the K clock. The bench supplies the divider and closes the loop.

The counter length comes from a four-bit code and may change while the loop is running. A nonzero code c gives c+2 stages, so the counter wraps at 2^(c+2). Code 0 stops the counter. Wrapping past the top yields a carry, and wrapping below zero yields a borrow. Both cross into the I/D clock domain. There they nudge a free-running toggle output: a carry moves the next toggle one I/D cycle earlier, and a borrow moves it one I/D cycle later. A short counter gives wide bandwidth and fast lock. A long counter gives narrow bandwidth and slow lock.

Top module: `dpll_core`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, on both clocks, `xor_pd_o`, `edge_pd_o` and `id_o` are 0 and all counters clear. This holds whether reset is applied at start-up or in the middle of operation.
- R2: `xor_pd_o` equals `ref_i` XOR `cmp_i`, three K clock cycles after the inputs settle.
- R3: `edge_pd_o` becomes 1 after a rising edge of `ref_i` and becomes 0 after a rising edge of `cmp_i`. When both rise in the same K clock cycle, it keeps its value.
- R4: `pd_sel` = 0 lets `xor_pd_o` steer the counter, and `pd_sel` = 1 lets `edge_pd_o` steer it. A steering value of 1 counts up and 0 counts down.
- R5: With `len_code` = 0 the counter makes no carries or borrows. `id_o` then toggles exactly once every two I/D clock cycles (I/D clock / 4), whatever the detectors do.
- R6: A nonzero `len_code` c gives a modulus of 2^(c+2). Counting up issues one carry per 2^(c+2) K clocks, and counting down issues one borrow per 2^(c+2) K clocks. Code 1 gives 8 and code 15 gives 131072.
- R7: Each carry makes `id_o` toggle one I/D cycle early, and each borrow delays a due toggle by one I/D cycle. Over a window of W I/D cycles, `id_o` therefore changes about (W + carries - borrows)/2 times.
- R8: A change of `len_code` takes effect without a reset. The count is reduced to the new length, and the carry rate follows the new modulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_k | input | 1 | K clock for the detectors and the up/down counter |
| clk_id | input | 1 | I/D clock for the toggle output |
| rst | input | 1 | Synchronous active-high reset, applied on both clocks |
| ref_i | input | 1 | Reference signal |
| cmp_i | input | 1 | Feedback signal from the external divide-by-N counter |
| len_code | input | 4 | Counter length code; 0 stops the counter |
| pd_sel | input | 1 | Steering select: 0 exclusive-OR detector, 1 edge detector |
| xor_pd_o | output | 1 | Exclusive-OR detector output |
| edge_pd_o | output | 1 | Edge-triggered detector output |
| id_o | output | 1 | Increment/decrement toggle output |

## Verification
Some rules are checked by the assertions on every cycle. The edge detector must settle to the right level after a lone rising edge. A stopped counter must never emit a carry or borrow, and a carry lasts exactly one K clock. `id_o` may toggle on two cycles in a row only when a carry is being consumed, and it reads zero after a reset cycle. Only the bench scenarios can show the longer behaviour: toggle counts over a window for each length code and direction, the effect of the select input, and the new carry rate after a mid-run code change.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

    localparam int CODE_W = 4;
    localparam int K_W    = (1 << CODE_W) + 1;

    typedef enum logic {
        PD_XOR  = 1'b0,
        PD_EDGE = 1'b1
    } pd_sel_e;

    typedef enum logic {
        PH_WAIT = 1'b0,
        PH_DUE  = 1'b1
    } ph_e;

    typedef struct packed {
        logic carry;
        logic borrow;
    } kevt_t;

    // mask of (code + 2) low ones; zero when the counter is stopped
    function automatic logic [K_W-1:0] stage_mask(input logic [CODE_W-1:0] code);
        logic [K_W-1:0] m;
        m = '0;
        for (int i = 0; i < K_W; i++) begin
            if ((code != '0) && (i < int'(code) + 2)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/dpll_sync.sv
module dpll_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dpll_phase_det.sv
module dpll_phase_det
    import dpll_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    ref_i,
    input  logic    cmp_i,
    input  pd_sel_e sel,
    output logic    xor_o,
    output logic    edge_o,
    output logic    dir_o
);
    logic ref_s, cmp_s, ref_d, cmp_d;
    logic rise_r, rise_c;
    logic xor_q, edge_q;

    dpll_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ref_i, cmp_i}),
        .q   ({ref_s, cmp_s})
    );

    assign rise_r = ref_s & ~ref_d;
    assign rise_c = cmp_s & ~cmp_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_d  <= 1'b0;
            cmp_d  <= 1'b0;
            xor_q  <= 1'b0;
            edge_q <= 1'b0;
        end else begin
            ref_d <= ref_s;
            cmp_d <= cmp_s;
            xor_q <= ref_s ^ cmp_s;
            if (rise_r && !rise_c)      edge_q <= 1'b1;
            else if (rise_c && !rise_r) edge_q <= 1'b0;
        end
    end

    assign xor_o  = xor_q;
    assign edge_o = edge_q;
    assign dir_o  = (sel == PD_EDGE) ? edge_q : xor_q;

    // R3
    ecpd_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rise_r && !rise_c) |=> edge_o);
    // R3
    ecpd_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (rise_c && !rise_r) |=> !edge_o);
endmodule

// File: rtl/dpll_kcounter.sv
module dpll_kcounter
    import dpll_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    input  logic              dir,
    output logic              carry_tgl,
    output logic              borrow_tgl
);
    logic [K_W-1:0] cnt_q, cnt_n, mask, cur;
    kevt_t          ev_n, ev_q;
    logic           tc_q, tb_q;

    assign mask = stage_mask(code);
    assign cur  = cnt_q & mask;

    always_comb begin
        cnt_n = cur;
        ev_n  = '0;
        if (code == '0) begin
            cnt_n = '0;
        end else if (dir) begin
            if (cur == mask) begin
                cnt_n      = '0;
                ev_n.carry = 1'b1;
            end else begin
                cnt_n = cur + 1'b1;
            end
        end else begin
            if (cur == '0) begin
                cnt_n       = mask;
                ev_n.borrow = 1'b1;
            end else begin
                cnt_n = cur - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ev_q  <= '0;
            tc_q  <= 1'b0;
            tb_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_n;
            ev_q  <= ev_n;
            tc_q  <= tc_q ^ ev_q.carry;
            tb_q  <= tb_q ^ ev_q.borrow;
        end
    end

    assign carry_tgl  = tc_q;
    assign borrow_tgl = tb_q;

    // R5
    kdis_chk: assert property (@(posedge clk) disable iff (rst)
        (code == '0) |=> (ev_q == '0));
    // R6
    carry_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ev_q.carry |=> !ev_q.carry);
    // R6
    borrow_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ev_q.borrow |=> !ev_q.borrow);
endmodule

// File: rtl/dpll_idpulse.sv
module dpll_idpulse
    import dpll_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic carry_tgl,
    input  logic borrow_tgl,
    output logic id_o
);
    logic c_s, b_s, c_d, b_d;
    logic new_c, new_b;
    logic pend_c, pend_b;
    logic use_c, use_b, tog;
    ph_e  ph_q, ph_n;
    logic out_q;

    dpll_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({carry_tgl, borrow_tgl}),
        .q   ({c_s, b_s})
    );

    assign new_c = c_s ^ c_d;
    assign new_b = b_s ^ b_d;

    always_comb begin
        tog   = 1'b0;
        use_c = 1'b0;
        use_b = 1'b0;
        ph_n  = ph_q;
        if (pend_c && pend_b) begin
            use_c = 1'b1;
            use_b = 1'b1;
            if (ph_q == PH_WAIT) begin
                ph_n = PH_DUE;
            end else begin
                tog  = 1'b1;
                ph_n = PH_WAIT;
            end
        end else if (ph_q == PH_WAIT) begin
            if (pend_c) begin
                tog   = 1'b1;
                use_c = 1'b1;
                ph_n  = PH_WAIT;
            end else begin
                ph_n = PH_DUE;
            end
        end else begin
            if (pend_b) begin
                use_b = 1'b1;
                ph_n  = PH_DUE;
            end else begin
                tog  = 1'b1;
                ph_n = PH_WAIT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_d    <= 1'b0;
            b_d    <= 1'b0;
            pend_c <= 1'b0;
            pend_b <= 1'b0;
            ph_q   <= PH_WAIT;
            out_q  <= 1'b0;
        end else begin
            c_d    <= c_s;
            b_d    <= b_s;
            pend_c <= (pend_c & ~use_c) | new_c;
            pend_b <= (pend_b & ~use_b) | new_b;
            ph_q   <= ph_n;
            out_q  <= out_q ^ tog;
        end
    end

    assign id_o = out_q;

    // R7
    id_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tog |=> (!tog || pend_c));
    // R1
    id_rst_chk: assert property (@(posedge clk)
        rst |=> !id_o);
endmodule

// File: rtl/dpll_core.sv
module dpll_core
    import dpll_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_k,
    input  logic              clk_id,
    input  logic              rst,
    input  logic              ref_i,
    input  logic              cmp_i,
    input  logic [CODE_W-1:0] len_code,
    input  logic              pd_sel,
    output logic              xor_pd_o,
    output logic              edge_pd_o,
    output logic              id_o
);
    logic dir;
    logic carry_tgl, borrow_tgl;

    dpll_phase_det #(.SYNC_STAGES(SYNC_STAGES)) u_pd (
        .clk    (clk_k),
        .rst    (rst),
        .ref_i  (ref_i),
        .cmp_i  (cmp_i),
        .sel    (pd_sel_e'(pd_sel)),
        .xor_o  (xor_pd_o),
        .edge_o (edge_pd_o),
        .dir_o  (dir)
    );

    dpll_kcounter u_kc (
        .clk        (clk_k),
        .rst        (rst),
        .code       (len_code),
        .dir        (dir),
        .carry_tgl  (carry_tgl),
        .borrow_tgl (borrow_tgl)
    );

    dpll_idpulse #(.SYNC_STAGES(SYNC_STAGES)) u_id (
        .clk        (clk_id),
        .rst        (rst),
        .carry_tgl  (carry_tgl),
        .borrow_tgl (borrow_tgl),
        .id_o       (id_o)
    );
endmodule

// File: tb/dpll_core_tb.sv
module dpll_core_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_i = 1'b0;
    logic       cmp_i = 1'b0;
    logic [3:0] len_code = 4'd0;
    logic       pd_sel = 1'b0;
    logic       xor_pd_o, edge_pd_o, id_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    localparam int WIN = 640;

    always #2 clk = ~clk;

    dpll_core u_dut (
        .clk_k     (clk),
        .clk_id    (clk),
        .rst       (rst),
        .ref_i     (ref_i),
        .cmp_i     (cmp_i),
        .len_code  (len_code),
        .pd_sel    (pd_sel),
        .xor_pd_o  (xor_pd_o),
        .edge_pd_o (edge_pd_o),
        .id_o      (id_o)
    );

    task automatic chk(input string req, input int act, input int exp, input int tol);
        total++;
        if (act > exp + tol || act < exp - tol) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst = 1'b1;
        cycles(4);
        rst = 1'b0;
    endtask

    task automatic measure(output int n);
        logic prev;
        n = 0;
        @(negedge clk);
        prev = id_o;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            if (id_o != prev) n++;
            prev = id_o;
        end
    endtask

    task automatic t_reset();
        ref_i = 1'b1; cmp_i = 1'b0; len_code = 4'd1; pd_sel = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        cycles(4);
        chk("R1 xor after reset", xor_pd_o, 0, 0);
        chk("R1 edge after reset", edge_pd_o, 0, 0);
        chk("R1 id after reset", id_o, 0, 0);
        rst = 1'b0;
        cycles(40);
        @(negedge clk);
        rst = 1'b1;
        cycles(2);
        chk("R1 xor mid-run reset", xor_pd_o, 0, 0);
        chk("R1 id mid-run reset", id_o, 0, 0);
        rst = 1'b0;
    endtask

    task automatic t_xor();
        pd_sel = 1'b0; len_code = 4'd0;
        pulse_reset();
        for (int k = 0; k < 4; k++) begin
            ref_i = k[0]; cmp_i = k[1];
            cycles(6);
            chk("R2 xor output", xor_pd_o, k[0] ^ k[1], 0);
        end
    endtask

    task automatic t_edge();
        pd_sel = 1'b1; len_code = 4'd0;
        ref_i = 1'b0; cmp_i = 1'b0;
        pulse_reset();
        cycles(4);
        ref_i = 1'b1; cycles(6);
        chk("R3 set by ref rise", edge_pd_o, 1, 0);
        cmp_i = 1'b1; cycles(6);
        chk("R3 clear by cmp rise", edge_pd_o, 0, 0);
        ref_i = 1'b0; cmp_i = 1'b0; cycles(6);
        ref_i = 1'b1; cmp_i = 1'b1; cycles(6);
        chk("R3 joint rise holds 0", edge_pd_o, 0, 0);
        ref_i = 1'b0; cycles(6);
        ref_i = 1'b1; cycles(6);
        ref_i = 1'b0; cmp_i = 1'b0; cycles(6);
        ref_i = 1'b1; cmp_i = 1'b1; cycles(6);
        chk("R3 joint rise holds 1", edge_pd_o, 1, 0);
    endtask

    task automatic t_disabled();
        int n;
        pd_sel = 1'b0; len_code = 4'd0; ref_i = 1'b1; cmp_i = 1'b0;
        pulse_reset();
        cycles(16);
        measure(n);
        chk("R5 stopped counter, detector high", n, WIN / 2, 0);
        ref_i = 1'b0;
        cycles(16);
        measure(n);
        chk("R5 stopped counter, detector low", n, WIN / 2, 0);
    endtask

    task automatic t_rate(input logic [3:0] code, input logic up, input int exp, input string req);
        int n;
        pd_sel = 1'b0; len_code = code; ref_i = up; cmp_i = 1'b0;
        pulse_reset();
        cycles(16);
        measure(n);
        chk(req, n, exp, 2);
    endtask

    task automatic t_select();
        int n;
        pd_sel = 1'b1; len_code = 4'd1; ref_i = 1'b0; cmp_i = 1'b0;
        pulse_reset();
        cycles(4);
        cmp_i = 1'b1; cycles(4);
        ref_i = 1'b1; cycles(16);
        measure(n);
        chk("R4 edge detector high steers up", n, (WIN + WIN / 8) / 2, 2);
        ref_i = 1'b0; cmp_i = 1'b0; cycles(4);
        cmp_i = 1'b1; cycles(16);
        measure(n);
        chk("R4 edge detector low steers down", n, (WIN - WIN / 8) / 2, 2);
    endtask

    task automatic t_dynamic();
        int n;
        pd_sel = 1'b0; len_code = 4'd1; ref_i = 1'b1; cmp_i = 1'b0;
        pulse_reset();
        cycles(16);
        measure(n);
        chk("R8 code 1 before change", n, (WIN + WIN / 8) / 2, 2);
        len_code = 4'd2;
        cycles(16);
        measure(n);
        chk("R8 code 2 after live change", n, (WIN + WIN / 16) / 2, 2);
        len_code = 4'd0;
        cycles(16);
        measure(n);
        chk("R8 stop after live change", n, WIN / 2, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_xor();
                t_edge();
                t_disabled();
                t_rate(4'd1, 1'b1, (WIN + WIN / 8) / 2, "R6 R7 code 1 up");
                t_rate(4'd1, 1'b0, (WIN - WIN / 8) / 2, "R6 R7 code 1 down");
                t_rate(4'd2, 1'b1, (WIN + WIN / 16) / 2, "R6 R7 code 2 up");
                t_rate(4'd3, 1'b0, (WIN - WIN / 32) / 2, "R6 R7 code 3 down");
                t_rate(4'd15, 1'b1, WIN / 2, "R6 code 15 up");
                t_select();
                t_dynamic();
                done = 1'b1;
            end
            begin
                repeat (150000) @(posedge clk);
                if (!done) begin
                    total++;
                    bad++;
                    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
                end
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule